// File: doc/BRIEF.md
# Gigabit Master/Slave Role Resolver

This block decides whether the local end of a 1000BASE-T link acts as clock master or clock slave. Software sets four control bits through a simple write port: manual-override enable, manual role value, port-type preference and the full-duplex gigabit advertisement. These bits go into a holding register. They move into the working copy only when autonegotiation enters its ability-detect step, so a write made at any other time waits for the next entry.

After an entry the block compares the working bits with the partner's matching bits and picks a role by priority. A manual override on either side wins first. A difference in port-type preference is used next. If neither settles it, the block falls back to comparing random seeds. The result is flagged valid only while the link runs at gigabit speed. If both sides force the same role, the block raises a fault instead of a role.

Top module: `gbe_role_resolver`

## Requirements
- R1: After reset role_valid and cfg_fault are 0, and adv_1000fdx is 1. Both the holding and working configurations reset to manual off, value 0, preference 0 and advertise 1.
- R2: cfg_wdata holds the fields as follows: bit 0 manual enable, bit 1 manual value, bit 2 port preference (1 = prefers master), bit 3 advertise 1000BASE-T full duplex. A write with abd_enter low changes neither adv_1000fdx nor the role outputs until the next abd_enter.
- R3: A write in the same cycle as abd_enter is captured by that entry.
- R4: With the latched manual enable at 1 and no conflict, the role follows the manual value (1 = master, 0 = slave), whatever the preference and seed inputs.
- R5: When the latched manual enable is 0, the manual value bit has no effect on the role.
- R6: If only the partner forces its role, the local side takes the opposite role.
- R7: If both sides force the same role, cfg_fault goes to 1 and role_valid stays 0. If they force opposite roles, the local manual value is used and the role is valid.
- R8: When neither side forces a role and the preferences differ, the local side takes the role it prefers.
- R9: When the preferences match, a valid seed comparison with the local seed larger gives master and a smaller local seed gives slave. Equal seeds keep role_valid at 0 until a later comparison differs.
- R10: Resolution happens only while speed_gig is 1. If speed_gig drops after a valid role, role_valid clears on the next cycle and the role is resolved again once speed_gig returns.
- R11: An abd_enter pulse clears role_valid and cfg_fault on the next clock edge. A role resolves one cycle later at the earliest.
- R12: adv_1000fdx equals the advertise bit held in the working configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for the holding configuration |
| cfg_wdata | input | 4 | Control bits to write (field layout in R2) |
| abd_enter | input | 1 | One-cycle pulse when ability detection is entered |
| lp_man_en | input | 1 | Partner manual-override enable |
| lp_man_val | input | 1 | Partner manual role value (1 = master) |
| lp_pref | input | 1 | Partner port-type preference (1 = prefers master) |
| speed_gig | input | 1 | Link resolved to 1000BASE-T |
| seed_vld | input | 1 | Seed comparison result is available |
| seed_gt | input | 1 | Local seed larger than partner seed |
| seed_eq | input | 1 | Seeds equal |
| role_master | output | 1 | 1 = local is master, 0 = slave |
| role_valid | output | 1 | role_master holds a resolved role |
| cfg_fault | output | 1 | Both sides forced the same role |
| adv_1000fdx | output | 1 | Advertise 1000BASE-T full duplex |

## Verification
A configuration write and an ability-detect entry can occur in the same cycle. The forwarded data must then win over the older held value. The bench drives cfg_wr and abd_enter together with a forced-master word. It then checks that the role which follows is master and valid, with no earlier write of that word. Another case lands a speed drop and a seed change in the resolve window. There the bench checks that role_valid stays low until both conditions allow a decision.

// File: rtl/role_pkg.sv
package role_pkg;
    // Control word layout: bit0 manual enable, bit1 manual value,
    // bit2 port preference, bit3 full-duplex advertise
    typedef struct packed {
        logic fdx;
        logic pref;
        logic val;
        logic en;
    } gcfg_t;

    localparam int CFG_W = $bits(gcfg_t);
    localparam gcfg_t CFG_RESET = '{fdx: 1'b1, pref: 1'b0, val: 1'b0, en: 1'b0};

    typedef enum logic [1:0] {
        DEC_WAIT   = 2'd0,
        DEC_MASTER = 2'd1,
        DEC_SLAVE  = 2'd2,
        DEC_FAULT  = 2'd3
    } dec_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RESOLVE = 2'd1,
        ST_DONE    = 2'd2
    } state_t;
endpackage

// File: rtl/role_cfg_regs.sv
module role_cfg_regs
    import role_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [CFG_W-1:0]     wdata,
    input  logic                 latch,
    output gcfg_t                active
);
    typedef struct packed {
        gcfg_t hold;
        gcfg_t act;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr) begin
            r_d.hold = gcfg_t'(wdata);
        end
        if (latch) begin
            r_d.act = wr ? gcfg_t'(wdata) : r_q.hold;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.hold <= CFG_RESET;
            r_q.act  <= CFG_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign active = r_q.act;

    // R2
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !latch |=> $stable(active));

    // R3
    fwd_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch && wr) |=> (active == gcfg_t'($past(wdata))));
endmodule

// File: rtl/role_decide.sv
module role_decide
    import role_pkg::*;
(
    input  gcfg_t  loc,
    input  logic   lp_en,
    input  logic   lp_val,
    input  logic   lp_pref,
    input  logic   seed_vld,
    input  logic   seed_gt,
    input  logic   seed_eq,
    output dec_t   dec
);
    always_comb begin
        if (loc.en && lp_en) begin
            if (loc.val == lp_val) dec = DEC_FAULT;
            else                   dec = loc.val ? DEC_MASTER : DEC_SLAVE;
        end else if (loc.en) begin
            dec = loc.val ? DEC_MASTER : DEC_SLAVE;
        end else if (lp_en) begin
            dec = lp_val ? DEC_SLAVE : DEC_MASTER;
        end else if (loc.pref != lp_pref) begin
            dec = loc.pref ? DEC_MASTER : DEC_SLAVE;
        end else if (!seed_vld || seed_eq) begin
            dec = DEC_WAIT;
        end else begin
            dec = seed_gt ? DEC_MASTER : DEC_SLAVE;
        end
    end
endmodule

// File: rtl/gbe_role_resolver.sv
module gbe_role_resolver
    import role_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [CFG_W-1:0]     cfg_wdata,
    input  logic                 abd_enter,
    input  logic                 lp_man_en,
    input  logic                 lp_man_val,
    input  logic                 lp_pref,
    input  logic                 speed_gig,
    input  logic                 seed_vld,
    input  logic                 seed_gt,
    input  logic                 seed_eq,
    output logic                 role_master,
    output logic                 role_valid,
    output logic                 cfg_fault,
    output logic                 adv_1000fdx
);
    gcfg_t act;
    dec_t  dec;

    typedef struct packed {
        state_t st;
        logic   master;
        logic   valid;
        logic   fault;
    } fsm_t;

    fsm_t f_d, f_q;

    role_cfg_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cfg_wr),
        .wdata  (cfg_wdata),
        .latch  (abd_enter),
        .active (act)
    );

    role_decide u_dec (
        .loc      (act),
        .lp_en    (lp_man_en),
        .lp_val   (lp_man_val),
        .lp_pref  (lp_pref),
        .seed_vld (seed_vld),
        .seed_gt  (seed_gt),
        .seed_eq  (seed_eq),
        .dec      (dec)
    );

    always_comb begin
        f_d = f_q;
        if (abd_enter) begin
            f_d.st    = ST_RESOLVE;
            f_d.valid = 1'b0;
            f_d.fault = 1'b0;
        end else begin
            unique case (f_q.st)
                ST_RESOLVE: begin
                    if (speed_gig) begin
                        unique case (dec)
                            DEC_MASTER: begin
                                f_d.master = 1'b1;
                                f_d.valid  = 1'b1;
                                f_d.st     = ST_DONE;
                            end
                            DEC_SLAVE: begin
                                f_d.master = 1'b0;
                                f_d.valid  = 1'b1;
                                f_d.st     = ST_DONE;
                            end
                            DEC_FAULT: begin
                                f_d.fault = 1'b1;
                                f_d.st    = ST_DONE;
                            end
                            default: ;
                        endcase
                    end
                end
                ST_DONE: begin
                    if (!speed_gig && !f_q.fault) begin
                        f_d.valid = 1'b0;
                        f_d.st    = ST_RESOLVE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q.st     <= ST_IDLE;
            f_q.master <= 1'b0;
            f_q.valid  <= 1'b0;
            f_q.fault  <= 1'b0;
        end else begin
            f_q <= f_d;
        end
    end

    assign role_master = f_q.master;
    assign role_valid  = f_q.valid;
    assign cfg_fault   = f_q.fault;
    assign adv_1000fdx = act.fdx;

    // R7
    fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_fault && role_valid));

    // R11
    entry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abd_enter |=> (!role_valid && !cfg_fault));

    // R10
    speed_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (role_valid && !speed_gig) |=> !role_valid);

    // R4
    manual_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == ST_RESOLVE && speed_gig && !abd_enter && act.en
         && !(lp_man_en && lp_man_val == act.val))
        |=> (role_valid && role_master == $past(act.val)));

    // R9
    seed_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!role_valid && !abd_enter && !act.en && !lp_man_en
         && act.pref == lp_pref && seed_eq) |=> !role_valid);
endmodule

// File: tb/sim_gbe_role_resolver.sv
module sim_gbe_role_resolver;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 1'b0;
    logic [3:0] cfg_wdata = 4'h0;
    logic abd_enter = 1'b0;
    logic lp_man_en = 1'b0, lp_man_val = 1'b0, lp_pref = 1'b0;
    logic speed_gig = 1'b1, seed_vld = 1'b1, seed_gt = 1'b0, seed_eq = 1'b0;
    logic role_master, role_valid, cfg_fault, adv_1000fdx;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    gbe_role_resolver u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .abd_enter(abd_enter), .lp_man_en(lp_man_en), .lp_man_val(lp_man_val),
        .lp_pref(lp_pref), .speed_gig(speed_gig), .seed_vld(seed_vld),
        .seed_gt(seed_gt), .seed_eq(seed_eq), .role_master(role_master),
        .role_valid(role_valid), .cfg_fault(cfg_fault), .adv_1000fdx(adv_1000fdx)
    );

    // Vector: [11:8] wdata, [7] lp_en, [6] lp_val, [5] lp_pref,
    //         [4] seed_gt, [3] seed_eq, [2] exp valid, [1] exp master, [0] exp fault
    localparam int NV = 12;
    localparam logic [11:0] VEC [NV] = '{
        {4'b1000, 3'b000, 2'b10, 3'b110},  // R9 local larger -> master
        {4'b1000, 3'b000, 2'b00, 3'b100},  // R9 local smaller -> slave
        {4'b1011, 3'b000, 2'b00, 3'b110},  // R4 forced master
        {4'b1001, 3'b001, 2'b10, 3'b100},  // R4 forced slave
        {4'b1010, 3'b000, 2'b00, 3'b100},  // R5 value ignored
        {4'b1000, 3'b110, 2'b10, 3'b100},  // R6 partner forces master
        {4'b0000, 3'b100, 2'b00, 3'b110},  // R6 partner forces slave
        {4'b1011, 3'b110, 2'b00, 3'b001},  // R7 both master -> fault
        {4'b1001, 3'b110, 2'b10, 3'b100},  // R7 opposite forced
        {4'b1100, 3'b000, 2'b00, 3'b110},  // R8 local prefers master
        {4'b1000, 3'b001, 2'b10, 3'b100},  // R8 partner prefers master
        {4'b1100, 3'b001, 2'b00, 3'b100}   // R9 same preference, seed smaller
    };

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [3:0] w);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = w;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic pulse_abd();
        @(negedge clk); abd_enter = 1'b1;
        @(negedge clk); abd_enter = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 valid", role_valid, 1'b0);
        chk("R1 fault", cfg_fault, 1'b0);
        chk("R1 adv", adv_1000fdx, 1'b1);
        // R1 default config: neither forced, equal prefs, seed larger -> master
        seed_gt = 1'b1;
        pulse_abd();
        @(negedge clk);
        chk("R1 default role valid", role_valid, 1'b1);
        chk("R1 default role master", role_master, 1'b1);

        for (int i = 0; i < NV; i++) begin
            wr_cfg(VEC[i][11:8]);
            lp_man_en = VEC[i][7]; lp_man_val = VEC[i][6]; lp_pref = VEC[i][5];
            seed_gt = VEC[i][4]; seed_eq = VEC[i][3];
            pulse_abd();
            @(negedge clk);
            chk("R4-vec valid", role_valid, VEC[i][2]);
            if (VEC[i][2]) chk("R8-vec master", role_master, VEC[i][1]);
            chk("R7-vec fault", cfg_fault, VEC[i][0]);
            chk("R12 adv", adv_1000fdx, VEC[i][11]);
        end

        // R11 entry clears fault: set up fault then re-enter
        wr_cfg(4'b1011);
        lp_man_en = 1'b1; lp_man_val = 1'b1; seed_eq = 1'b0;
        pulse_abd();
        @(negedge clk);
        chk("R7 fault set", cfg_fault, 1'b1);
        lp_man_en = 1'b0;
        pulse_abd();
        chk("R11 fault cleared", cfg_fault, 1'b0);
        chk("R11 valid cleared", role_valid, 1'b0);
        @(negedge clk);
        chk("R11 resolves next", role_valid, 1'b1);
        chk("R4 master after clear", role_master, 1'b1);

        // R11 valid cleared one cycle after entry
        pulse_abd();
        chk("R11 valid clear", role_valid, 1'b0);
        @(negedge clk);

        // R2 write without entry has no effect
        wr_cfg(4'b0001);
        repeat (3) @(negedge clk);
        chk("R2 adv unchanged", adv_1000fdx, 1'b1);
        chk("R2 role unchanged", role_master, 1'b1);
        chk("R2 valid unchanged", role_valid, 1'b1);
        pulse_abd();
        @(negedge clk);
        chk("R2 adv after entry", adv_1000fdx, 1'b0);
        chk("R2 role after entry", role_master, 1'b0);

        // R3 write in same cycle as entry
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = 4'b1011; abd_enter = 1'b1;
        @(negedge clk); cfg_wr = 1'b0; abd_enter = 1'b0;
        @(negedge clk);
        chk("R3 same-cycle master", role_master, 1'b1);
        chk("R3 same-cycle valid", role_valid, 1'b1);
        chk("R3 same-cycle adv", adv_1000fdx, 1'b1);

        // R9 equal seeds wait, then resolve
        wr_cfg(4'b1000);
        lp_pref = 1'b0; seed_eq = 1'b1; seed_gt = 1'b0;
        pulse_abd();
        repeat (3) @(negedge clk);
        chk("R9 tie waits", role_valid, 1'b0);
        seed_eq = 1'b0; seed_gt = 1'b1;
        @(negedge clk);
        chk("R9 retry valid", role_valid, 1'b1);
        chk("R9 retry master", role_master, 1'b1);

        // R10 speed gating
        speed_gig = 1'b0;
        @(negedge clk);
        chk("R10 drop clears", role_valid, 1'b0);
        seed_gt = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 waits for speed", role_valid, 1'b0);
        speed_gig = 1'b1;
        @(negedge clk);
        chk("R10 resolves again", role_valid, 1'b1);
        chk("R10 new role", role_master, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule